// File: doc/BRIEF.md
# Banked Interrupt Controller with Fast-Interrupt Routing

This block collects level-sensitive interrupt requests from seven local sources and from two 32-bit banks of external sources. It drives two outputs: a combined interrupt line (`irqOut`) and a separate fast-interrupt line (`fiqOut`). Each of the three groups (local, bank A, bank B) has two write ports. Writing ones to the set port turns enables on. Writing ones to the clear port turns them off. Reading either port returns the live enable word.

A summary word gives a quick view:
- the four lowest local requests appear as raw bits;
- a single bit per bank says whether any enabled request in that bank is active.

One control register picks exactly one source by a 7-bit index and routes it to the fast line. While fast routing is on, that source is removed from the combined line.

Software reaches the block through a simple register port. Writes are synchronous. Reads are combinational from a word address.

Top module: `irqFiqController`

## Requirements
- R1: After reset all enables and the fast-routing control word are zero, and both `irqOut` and `fiqOut` are low.
- R2: Reading offset 0x0 returns the raw local requests timer, mailbox, doorbell 0 and doorbell 1 in bits 0, 1, 2 and 3.
- R3: Offset 0x0 bit 8 is high when any bank A request with its enable set is active, and bit 9 is high for the same condition in bank B. All other bits of offset 0x0 read zero.
- R4: Offsets 0x1 and 0x2 return the raw request levels of bank A and bank B, whatever the enables.
- R5: Writing to offset 0x4 (local), 0x5 (bank A) or 0x6 (bank B) sets every enable bit written as one. Zero bits leave the enables unchanged. Reading these offsets returns the current enables.
- R6: Writing to offset 0x8 (local), 0x9 (bank A) or 0xA (bank B) clears every enable bit written as one. Reading these offsets returns the current enables.
- R7: The local enable and request bits are ordered as follows: 0 timer, 1 mailbox, 2 doorbell 0, 3 doorbell 1, 4 coprocessor-0 halt, 5 coprocessor-1 halt, 6 illegal access.
- R8: Offset 0x3 holds the fast-routing control: the source index in bits 6:0 and the routing enable in bit 7. It reads back as written.
- R9: The routing index is decoded as follows:
  - 0x00 to 0x1F select bank A bits 0 to 31;
  - 0x20 to 0x3F select bank B bits 0 to 31;
  - 0x40 to 0x46 select local bits 0 to 6.
- R10: `fiqOut` is high exactly when routing is enabled and the selected request is active, independent of the group enables.
- R11: Indices 0x47 to 0x7F never raise `fiqOut`.
- R12: `irqOut` is high when an enabled, active request exists that is not the source currently routed to the fast line with routing enabled.
- R13: Requests are levels. Outputs and status follow the inputs with no latching, and enable or control writes take effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localSrc | input | 7 | Local request levels, ordered as in R7 |
| bankASrc | input | 32 | Bank A request levels |
| bankBSrc | input | 32 | Bank B request levels |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| irqOut | output | 1 | Combined interrupt |
| fiqOut | output | 1 | Fast interrupt |

## Verification
On every cycle, the assertions check the enable-register rules:
- a set write leaves each written one set;
- a clear write removes each written one;
- without a write, the enables hold.

They also check that the fast line stays low when routing is off or the index lies past the last source.

Only the bench scenarios can show the index decode across both banks and the local group, and the removal of the routed source from the combined line. The same applies to the summary bank bits and to level-following when a request drops.

// File: rtl/irqPkg.sv
package irqPkg;

  // register word offsets
  localparam logic [3:0] OFF_SUMMARY = 4'h0;
  localparam logic [3:0] OFF_RAW_A   = 4'h1;
  localparam logic [3:0] OFF_RAW_B   = 4'h2;
  localparam logic [3:0] OFF_FIQ     = 4'h3;
  localparam logic [3:0] OFF_SET_L   = 4'h4;
  localparam logic [3:0] OFF_SET_A   = 4'h5;
  localparam logic [3:0] OFF_SET_B   = 4'h6;
  localparam logic [3:0] OFF_CLR_L   = 4'h8;
  localparam logic [3:0] OFF_CLR_A   = 4'h9;
  localparam logic [3:0] OFF_CLR_B   = 4'hA;

  // summary word layout
  localparam int SUM_LOCAL_W = 4;
  localparam int SUM_BIT_A   = 8;
  localparam int SUM_BIT_B   = 9;

  typedef enum logic [2:0] {
    RD_NONE, RD_SUMMARY, RD_RAW_A, RD_RAW_B, RD_FIQ, RD_EN_L, RD_EN_A, RD_EN_B
  } rdSel_t;

  typedef struct packed {
    logic   setL;
    logic   setA;
    logic   setB;
    logic   clrL;
    logic   clrA;
    logic   clrB;
    logic   fiqWr;
    rdSel_t rdSel;
  } strobes_t;

endpackage

// File: rtl/irqRegDecode.sv
module irqRegDecode
  import irqPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobes_t          stb
);

  logic [3:0] addr4;
  assign addr4 = 4'(regAddr);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    unique case (addr4)
      OFF_SUMMARY: stb.rdSel = RD_SUMMARY;
      OFF_RAW_A:   stb.rdSel = RD_RAW_A;
      OFF_RAW_B:   stb.rdSel = RD_RAW_B;
      OFF_FIQ:     begin stb.rdSel = RD_FIQ;  stb.fiqWr = regWe; end
      OFF_SET_L:   begin stb.rdSel = RD_EN_L; stb.setL  = regWe; end
      OFF_SET_A:   begin stb.rdSel = RD_EN_A; stb.setA  = regWe; end
      OFF_SET_B:   begin stb.rdSel = RD_EN_B; stb.setB  = regWe; end
      OFF_CLR_L:   begin stb.rdSel = RD_EN_L; stb.clrL  = regWe; end
      OFF_CLR_A:   begin stb.rdSel = RD_EN_A; stb.clrA  = regWe; end
      OFF_CLR_B:   begin stb.rdSel = RD_EN_B; stb.clrB  = regWe; end
      default:     stb.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/irqEnableReg.sv
module irqEnableReg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setStb,
  input  logic         clrStb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] setMask;
  logic [W-1:0] clrMask;

  assign setMask = setStb ? wdata : '0;
  assign clrMask = clrStb ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) q <= '0;
    else       q <= (q | setMask) & ~clrMask;
  end

  AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    setStb |=> ((q & $past(wdata)) == $past(wdata))); // R5
  AST_CLR_DROPS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |=> ((q & $past(wdata)) == '0)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!setStb && !clrStb) |=> $stable(q)); // R5

endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int BANK_W    = 32,
  parameter int LOCAL_W   = 7,
  parameter int DATA_W    = 32,
  parameter int FIQ_IDX_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [LOCAL_W-1:0] localSrc,
  input  logic [BANK_W-1:0]  bankASrc,
  input  logic [BANK_W-1:0]  bankBSrc,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irqOut,
  output logic               fiqOut
);

  localparam int ALL_W    = 2 * BANK_W + LOCAL_W;
  localparam int IDX_SPAN = 2 ** FIQ_IDX_W;
  localparam int CTRL_W   = FIQ_IDX_W + 1;
  localparam int LAST_IDX = ALL_W - 1;

  logic [LOCAL_W-1:0]  enL;
  logic [BANK_W-1:0]   enA;
  logic [BANK_W-1:0]   enB;
  logic [CTRL_W-1:0]   fiqCtrl;
  logic [FIQ_IDX_W-1:0] fiqIdx;
  logic                fiqOn;
  logic [IDX_SPAN-1:0] padPend;
  logic [IDX_SPAN-1:0] padEn;
  logic [IDX_SPAN-1:0] routeMask;
  logic [DATA_W-1:0]   sumWord;

  irqEnableReg #(.W(LOCAL_W)) uEnL (
    .clk(clk), .rstN(rstN), .setStb(stb.setL), .clrStb(stb.clrL),
    .wdata(regWdata[LOCAL_W-1:0]), .q(enL));
  irqEnableReg #(.W(BANK_W)) uEnA (
    .clk(clk), .rstN(rstN), .setStb(stb.setA), .clrStb(stb.clrA),
    .wdata(regWdata[BANK_W-1:0]), .q(enA));
  irqEnableReg #(.W(BANK_W)) uEnB (
    .clk(clk), .rstN(rstN), .setStb(stb.setB), .clrStb(stb.clrB),
    .wdata(regWdata[BANK_W-1:0]), .q(enB));

  always_ff @(posedge clk) begin
    if (!rstN)          fiqCtrl <= '0;
    else if (stb.fiqWr) fiqCtrl <= regWdata[CTRL_W-1:0];
  end

  assign fiqIdx = fiqCtrl[FIQ_IDX_W-1:0];
  assign fiqOn  = fiqCtrl[FIQ_IDX_W];

  // index space: bank A, bank B, then local group; unused slots read zero
  assign padPend   = IDX_SPAN'({localSrc, bankBSrc, bankASrc});
  assign padEn     = IDX_SPAN'({enL, enB, enA});
  assign routeMask = fiqOn ? (IDX_SPAN'(1) << fiqIdx) : '0;

  assign fiqOut = fiqOn & padPend[fiqIdx];
  assign irqOut = |(padPend & padEn & ~routeMask);

  always_comb begin
    sumWord = '0;
    sumWord[SUM_LOCAL_W-1:0] = localSrc[SUM_LOCAL_W-1:0];
    sumWord[SUM_BIT_A] = |(bankASrc & enA);
    sumWord[SUM_BIT_B] = |(bankBSrc & enB);
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_SUMMARY: regRdata = sumWord;
      RD_RAW_A:   regRdata = DATA_W'(bankASrc);
      RD_RAW_B:   regRdata = DATA_W'(bankBSrc);
      RD_FIQ:     regRdata = DATA_W'(fiqCtrl);
      RD_EN_L:    regRdata = DATA_W'(enL);
      RD_EN_A:    regRdata = DATA_W'(enA);
      RD_EN_B:    regRdata = DATA_W'(enB);
      default:    regRdata = '0;
    endcase
  end

  AST_FIQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    !fiqCtrl[FIQ_IDX_W] |-> !fiqOut); // R10
  AST_HIGH_IDX_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (int'(fiqCtrl[FIQ_IDX_W-1:0]) > LAST_IDX) |-> !fiqOut); // R11
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rstN |=> (fiqCtrl == '0 && enL == '0)); // R1

endmodule

// File: rtl/irqFiqController.sv
module irqFiqController
  import irqPkg::*;
#(
  parameter int BANK_W    = 32,
  parameter int LOCAL_W   = 7,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int FIQ_IDX_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LOCAL_W-1:0] localSrc,
  input  logic [BANK_W-1:0]  bankASrc,
  input  logic [BANK_W-1:0]  bankBSrc,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irqOut,
  output logic               fiqOut
);

  strobes_t stb;

  irqRegDecode #(.ADDR_W(ADDR_W)) uDecode (
    .regWe(regWe), .regAddr(regAddr), .stb(stb));

  irqDatapath #(
    .BANK_W(BANK_W), .LOCAL_W(LOCAL_W), .DATA_W(DATA_W), .FIQ_IDX_W(FIQ_IDX_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .localSrc(localSrc), .bankASrc(bankASrc), .bankBSrc(bankBSrc),
    .regWdata(regWdata), .regRdata(regRdata),
    .irqOut(irqOut), .fiqOut(fiqOut));

endmodule

// File: tb/irqFiqController_test.sv
module irqFiqController_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  localSrc = '0;
  logic [31:0] bankASrc = '0;
  logic [31:0] bankBSrc = '0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;
  logic        fiqOut;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int          sel;   // 0 irq, 1 fiq, 2 read data
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  item_t cur;
  logic [31:0] act;

  always #2.5 clk = ~clk;

  irqFiqController uut (
    .clk(clk), .rstN(rstN), .localSrc(localSrc), .bankASrc(bankASrc),
    .bankBSrc(bankBSrc), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .fiqOut(fiqOut));

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      cur = sb.pop_front();
      case (cur.sel)
        0:       act = {31'b0, irqOut};
        1:       act = {31'b0, fiqOut};
        default: act = regRdata;
      endcase
      vectors++;
      if (act !== cur.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", cur.tag, cur.sel, act, cur.exp);
      end
    end
  end

  task automatic push(input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    settle();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic chkRd(input logic [3:0] a, input logic [31:0] e, input string tag);
    regAddr = a;
    push(2, e, tag);
    settle();
  endtask

  task automatic chkIrq(input logic e, input string tag);
    push(0, {31'b0, e}, tag);
    settle();
  endtask

  task automatic chkFiq(input logic e, input string tag);
    push(1, {31'b0, e}, tag);
    settle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    settle();
    // R1 reset state
    chkIrq(1'b0, "R1");
    chkFiq(1'b0, "R1");
    chkRd(4'h4, 32'h0, "R1");
    chkRd(4'h3, 32'h0, "R1");
    // R2 raw local bits in summary
    localSrc = 7'h55;
    chkRd(4'h0, 32'h5, "R2");
    chkIrq(1'b0, "R12");
    // R4 raw bank, R3 needs enable
    bankASrc = 32'h8000_0001;
    chkRd(4'h1, 32'h8000_0001, "R4");
    chkRd(4'h0, 32'h5, "R3");
    // R5 set, R6 readback via clear offset
    wr(4'h5, 32'h1);
    chkRd(4'h5, 32'h1, "R5");
    chkRd(4'h9, 32'h1, "R6");
    chkRd(4'h0, 32'h105, "R3");
    chkIrq(1'b1, "R12");
    wr(4'h5, 32'h0);
    chkRd(4'h5, 32'h1, "R5");
    wr(4'h5, 32'h10);
    chkRd(4'h5, 32'h11, "R5");
    wr(4'h9, 32'h1);
    chkRd(4'h5, 32'h10, "R6");
    chkRd(4'h0, 32'h5, "R3");
    chkIrq(1'b0, "R6");
    // R7 local positions
    wr(4'h4, 32'h40);
    chkIrq(1'b1, "R7");
    chkRd(4'h4, 32'h40, "R7");
    wr(4'h8, 32'h40);
    chkIrq(1'b0, "R6");
    wr(4'h4, 32'h10);
    chkIrq(1'b1, "R7");
    wr(4'h8, 32'h10);
    wr(4'h4, 32'h08);
    chkIrq(1'b0, "R7");
    wr(4'h8, 32'h08);
    // R8/R9 routing to illegal-access source
    wr(4'h3, 32'hC6);
    chkFiq(1'b1, "R9");
    chkIrq(1'b0, "R12");
    chkRd(4'h3, 32'hC6, "R8");
    wr(4'h4, 32'h40);
    chkIrq(1'b0, "R12");
    wr(4'h4, 32'h01);
    chkIrq(1'b1, "R12");
    wr(4'h8, 32'h41);
    chkIrq(1'b0, "R12");
    // R9 external decode
    wr(4'h3, 32'h80);
    chkFiq(1'b1, "R9");
    wr(4'h3, 32'h9F);
    chkFiq(1'b1, "R9");
    wr(4'h3, 32'hA0);
    chkFiq(1'b0, "R9");
    bankBSrc = 32'h1;
    chkFiq(1'b1, "R13");
    chkRd(4'h2, 32'h1, "R4");
    bankBSrc = 32'h0;
    chkFiq(1'b0, "R13");
    // R11 out-of-range indices
    localSrc = 7'h7F;
    wr(4'h3, 32'hC7);
    chkFiq(1'b0, "R11");
    wr(4'h3, 32'hFF);
    chkFiq(1'b0, "R11");
    // R8 enable bit, R10
    wr(4'h3, 32'h40);
    chkFiq(1'b0, "R8");
    wr(4'h3, 32'hC0);
    chkFiq(1'b1, "R10");
    localSrc = 7'h7E;
    chkFiq(1'b0, "R13");
    // R3 bank B summary, R13 on combined line
    wr(4'h6, 32'h20);
    bankBSrc = 32'h20;
    chkRd(4'h0, 32'h20E, "R3");
    chkIrq(1'b1, "R13");
    bankBSrc = 32'h0;
    chkRd(4'h0, 32'hE, "R3");
    chkIrq(1'b0, "R13");
    settle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule